// File: doc/BRIEF.md
# Change-Compressed Logic Capture Engine

The block watches a 32-bit input port once per clock and writes to a memory write port only when something worth keeping happens. While the masked input bits keep moving, every raw 32-bit sample goes out, each at the next word address. On the first quiet clock after one or more samples, the block emits a packed summary word instead. The summary holds how many samples came since the previous summary and how many clocks elapsed. Raw samples and summaries share one stream.

Each summary's word address is kept in a readable register. Software reads that register to find the newest summary, then walks the log backwards from it. Reading the register clears it, which tells the capture side that the value has been collected. A long quiet stretch produces a timeout summary, so time never goes unaccounted. Arming, triggering and memory arbitration sit outside this block.

Top module: `chg_capture`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears all state. After that edge, `mem_we` is 0, `mem_addr` is 0 and `last_off` is 0.
- R2: The first enabled clock after reset always writes the raw input as a sample, whatever the mask says.
- R3: On an enabled clock where `(din ^ previous sample) & mask` is nonzero, the block writes `din` unchanged at the next word address. Each write, sample or summary, uses an address one above the previous write's address, modulo 2^AW.
- R4: A change confined to input bits whose `mask` bit is 0 counts as no change. It writes no sample.
- R5: On the first unchanged clock after one or more samples, the block writes a summary. Bits 31:24 hold the sample count and bits 23:0 hold the elapsed-clock value.
- R6: Further unchanged clocks, with no samples pending and no timeout reached, write nothing.
- R7: The elapsed-clock counter starts at 0 on the clock after a summary. It rises by one on every enabled clock that writes no summary, whether or not a sample is written. Example: four changes, four quiet clocks, two changes, one quiet clock yields summary 0x02000005.
- R8: When the elapsed counter equals TIMEOUT (default 0xFFFF00) on an unchanged clock with a count of 0, the block writes a timeout summary. Its count is 0 and its time is TIMEOUT.
- R9: If 255 samples are pending at the start of an enabled clock, that clock writes a summary with count 255. The stored previous sample is not updated, so a still-different input is written as a sample on the next clock.
- R10: Each summary write copies that summary's word address into `last_off`, visible after the same edge that drives the write outputs.
- R11: A clock with `rd_last` high clears `last_off` to 0, unless a summary is written on that same clock, in which case the new address wins.
- R12: While `en` is low, nothing is written and the counters and stored sample hold. `rd_last` still works.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Capture enable |
| din | input | 32 | Sampled input port |
| mask | input | 32 | Bits that count as a change |
| rd_last | input | 1 | Read strobe for the last-summary register (clears it) |
| last_off | output | AW | Word address of the newest summary |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |

## Verification
The bench replays the worked sequence of changes and quiet clocks and pins the exact summary word and address. A design whose time counter resets one clock late, or that skips counting on sample clocks, would put a wrong time field there. A design with an off-by-one counter would stop a quiet stretch one clock early or late, and a small TIMEOUT exposes that. A stream of 300 distinct values forces a 255-count summary. A design that wraps the count would emit a summary with count 0, and one that updates the stored sample on the forced clock would drop the following sample. Reads that collide with a summary write, and toggling of masked-out bits, catch a clear that wins over the new address and a mask applied to the wrong side.

// File: rtl/chg_capture.sv
module chg_capture #(
  parameter int AW = 12,
  parameter int TW = 24,
  parameter int unsigned TIMEOUT = 32'hFFFF00
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [31:0]   din,
  input  logic [31:0]   mask,
  input  logic          rd_last,
  output logic [AW-1:0] last_off,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata
);
  localparam int CW = 32 - TW;

  logic [31:0]   prev_q;
  logic          have_q;
  logic [CW-1:0] cnt_q;
  logic [TW-1:0] tmr_q;
  logic [AW-1:0] wptr_q;
  logic          rec_q;

  logic chg, full, quiet_to, do_rec, do_smp;

  assign chg      = !have_q || (((din ^ prev_q) & mask) != 32'd0);
  assign full     = &cnt_q;
  assign quiet_to = tmr_q == TIMEOUT[TW-1:0];
  assign do_rec   = en && (full || (!chg && (cnt_q != '0 || quiet_to)));
  assign do_smp   = en && !full && chg;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q    <= '0;
      have_q    <= 1'b0;
      cnt_q     <= '0;
      tmr_q     <= '0;
      wptr_q    <= '0;
      last_off  <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rec_q     <= 1'b0;
    end else begin
      mem_we <= do_rec || do_smp;
      rec_q  <= do_rec;
      if (do_rec || do_smp) begin
        mem_addr <= wptr_q;
        wptr_q   <= wptr_q + 1'b1;
      end
      if (do_rec) begin
        mem_wdata <= {cnt_q, tmr_q};
        cnt_q     <= '0;
        tmr_q     <= '0;
        last_off  <= wptr_q;
      end else begin
        if (rd_last) last_off <= '0;
        if (en) tmr_q <= tmr_q + 1'b1;
      end
      if (do_smp) begin
        mem_wdata <= din;
        prev_q    <= din;
        have_q    <= 1'b1;
        cnt_q     <= cnt_q + 1'b1;
      end
    end
  end
endmodule

module chg_capture_chk #(
  parameter int AW = 12,
  parameter int TW = 24,
  parameter int unsigned TIMEOUT = 32'hFFFF00
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          rd_last,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic [AW-1:0] last_off,
  input logic          rec_q
);
  logic [AW-1:0] lw;
  logic          seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      lw   <= '0;
      seen <= 1'b0;
    end else if (mem_we) begin
      lw   <= mem_addr;
      seen <= 1'b1;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!mem_we && mem_addr == '0 && last_off == '0));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && seen) |-> mem_addr == lw + 1'b1);

  // R8
  timeout_rec_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && rec_q && mem_wdata[31:TW] == '0) |-> mem_wdata[TW-1:0] == TIMEOUT[TW-1:0]);

  // R10
  last_track_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && rec_q) |-> last_off == mem_addr);

  // R11
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rd_last |=> (last_off == '0 || (mem_we && rec_q)));

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !mem_we);
endmodule

bind chg_capture chg_capture_chk #(.AW(AW), .TW(TW), .TIMEOUT(TIMEOUT)) u_chk (
  .clk(clk), .rst(rst), .en(en), .rd_last(rd_last), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .last_off(last_off), .rec_q(rec_q)
);

// File: tb/sim_chg_capture.sv
module sim_chg_capture;
  localparam int AW = 12;
  localparam int unsigned TO = 64;

  logic clk = 0, rst = 1, en = 0, rd_last = 0;
  logic [31:0] din = 0, mask = 32'hFFFFFFFF;
  logic [AW-1:0] last_off, mem_addr;
  logic mem_we;
  logic [31:0] mem_wdata;

  int checks = 0, failures = 0;
  string phase = "R1";

  chg_capture #(.AW(AW), .TIMEOUT(TO)) u0 (
    .clk(clk), .rst(rst), .en(en), .din(din), .mask(mask), .rd_last(rd_last),
    .last_off(last_off), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata));

  always #5 clk = ~clk;

  // behavioural reference
  logic [31:0] m_prev; bit m_have; int m_cnt, m_tmr, m_wp, m_last;
  bit e_we; int e_addr; logic [31:0] e_data; string e_tag;

  always @(posedge clk) begin
    bit chg, rec;
    if (rst) begin
      m_prev = 0; m_have = 0; m_cnt = 0; m_tmr = 0; m_wp = 0; m_last = 0;
      e_we = 0; e_addr = 0; e_data = 0; e_tag = "R1";
    end else begin
      rec = 0; e_we = 0; e_tag = en ? "R6" : "R12";
      chg = !m_have || (((din ^ m_prev) & mask) != 0);
      if (en) begin
        if (m_cnt == 255) begin
          rec = 1; e_tag = "R9";
        end else if (chg) begin
          e_we = 1; e_addr = m_wp; e_data = din; e_tag = m_have ? "R3" : "R2";
          m_wp = (m_wp + 1) % (1 << AW);
          m_prev = din; m_have = 1; m_cnt++; m_tmr++;
        end else if (m_cnt != 0 || m_tmr == TO) begin
          rec = 1; e_tag = (m_cnt == 0) ? "R8" : "R5";
        end else m_tmr++;
        if (rec) begin
          e_we = 1; e_addr = m_wp; e_data = (m_cnt << 24) | m_tmr;
          m_last = m_wp; m_wp = (m_wp + 1) % (1 << AW);
          m_cnt = 0; m_tmr = 0;
        end
      end
      if (rd_last && !rec) m_last = 0;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s/%s act=%h exp=%h", tag, phase, act, exp);
    end
  endtask

  task automatic tick(input logic [31:0] d);
    din = d;
    @(posedge clk); #3;
    chk(e_tag, mem_we, e_we);
    if (e_we) begin
      chk(e_tag, mem_addr, e_addr);
      chk(e_tag, mem_wdata, e_data);
    end
    chk("R10", last_off, m_last);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #3;
    chk("R1", mem_we, 0); chk("R1", mem_addr, 0); chk("R1", last_off, 0);
    rst = 0; en = 1;
    phase = "R7";
    tick(1); tick(2); tick(3); tick(4);
    tick(4); tick(4); tick(4); tick(4);
    tick(5); tick(6); tick(6);
    chk("R7", mem_wdata, 32'h02000005);
    chk("R10", last_off, 7);
    phase = "R4"; mask = 32'h0000FFFF;
    for (int i = 0; i < 6; i++) tick(32'h00010006 << (i % 2) | 32'h6);
    tick(32'h00000007); tick(32'hAB000007);
    phase = "R8";
    for (int i = 0; i < 2 * TO + 10; i++) tick(32'h00000007);
    phase = "R11"; rd_last = 1; tick(32'h00000007); rd_last = 0;
    chk("R11", last_off, 0);
    phase = "R12"; en = 0;
    for (int i = 0; i < 5; i++) tick(32'h100 + i);
    en = 1; mask = 32'hFFFFFFFF;
    phase = "R9";
    for (int i = 0; i < 300; i++) tick(32'h1000 + i);
    phase = "R11";
    tick(32'h5555); rd_last = 1; tick(32'h5555); rd_last = 0;
    tick(32'h5555);
    phase = "R5";
    for (int i = 0; i < 3; i++) tick(32'h6000 + i);
    tick(32'h6002); tick(32'h6002);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule